// File: doc/BRIEF.md
# Shared-Unit Read-Modify-Write Scatter Datapath

This block runs a fixed six-step loop body on one signed multiplier and one signed adder, both 64 bits wide and both purely combinational. Each pass forms x = a*b, then y = c+d, then z = x+y. It uses the low bits of z as an address into an internal 512-entry, 64-bit memory. It reads that word, multiplies it by f and writes the product back to the same location. Four 8-to-1 operand selectors feed the two units. Their selects are decoded from the current state. The eight candidate operands are the five operand ports, the x and y registers, and the memory read data.

A controller leaves its idle state when `start` is seen and runs `iter_count` passes. It then returns to idle and raises `done` for one cycle. Two side ports serve setup and inspection. While the block is idle, `load_en`, `load_addr` and `load_data` write the memory. `peek_addr` reads any word through a separate read port, and the word appears on `peek_data` one cycle later.

States and transitions: IDLE goes to MUL_AB on `start` when the count is non-zero. The body always runs in the order MUL_AB (x from a*b), ADD_CD (y from c+d), ADD_XY (z from x+y), RD_ADDR (memory address from z), MUL_QF (w from read data times f) and WR (same address, write enable high, data from w). WR goes back to MUL_AB while passes remain, and to IDLE after the last one.

Top module: `scatter_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the controller to IDLE with `busy` and `done` low and clears x, y, z and w. Memory contents survive the reset.
- R2: In IDLE, a `start` sampled high with a non-zero `iter_count` enters MUL_AB at that edge. `busy` (high whenever the state is not IDLE) is then high from the following cycle until the pass count is used up.
- R3: Every pass takes exactly six cycles in the fixed order MUL_AB, ADD_CD, ADD_XY, RD_ADDR, MUL_QF, WR. For a count of N ≥ 1, `done` is high in the cycle that follows rising edge 6N+1, counting the start edge as edge 1.
- R4: Products keep the low 64 bits of the signed result, and sums wrap modulo 2^64.
- R5: The memory address is z[8:0], the low nine bits of z in two's complement. The higher bits of z have no effect, so z = -1 addresses word 511.
- R6: Each pass replaces the addressed word m with m*f. After N passes the word holds m*f^N modulo 2^64. The read data is the word as it stood one cycle after RD_ADDR presented the address.
- R7: The memory is written only in WR during a run. All words other than the addressed one keep their values.
- R8: `done` is a one-cycle pulse. A `start` with `iter_count` = 0 pulses `done` in the next cycle, leaves `busy` low and changes no memory word.
- R9: `load_en` writes `load_data` to `load_addr` at a rising edge only while the state is IDLE. During a run it is ignored.
- R10: `peek_data` shows the word at the `peek_addr` sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run from IDLE |
| iter_count | input | 16 | Number of loop passes in the run |
| op_a | input | 64 | Signed multiplicand for x |
| op_b | input | 64 | Signed multiplier for x |
| op_c | input | 64 | Signed addend for y |
| op_d | input | 64 | Signed addend for y |
| op_f | input | 64 | Signed scale applied to the memory word |
| load_en | input | 1 | Memory write strobe, honoured only in IDLE |
| load_addr | input | 9 | Memory write address for loads |
| load_data | input | 64 | Memory write data for loads |
| peek_addr | input | 9 | Inspection read address |
| peek_data | output | 64 | Inspection read data, one cycle after the address |
| busy | output | 1 | High while the state is not IDLE |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The hardest case to reach from the ports is a load strobe that arrives while a run is in progress. It has to hit a word that the run itself never touches, so that any leak through the write path shows up as a changed word and cannot be hidden by the loop's own write. The bench preloads a spare word while the block is idle. It starts a run aimed at a different address and drives `load_en` with new data to the spare word during the first busy cycles. After `done`, it peeks the spare word. Separate vectors bring about address aliasing through negative z, and wrap-around in both units through operands whose exact product is 2^70 and whose sum crosses the signed maximum.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MUL_AB  = 3'd1,
        ST_ADD_CD  = 3'd2,
        ST_ADD_XY  = 3'd3,
        ST_RD_ADDR = 3'd4,
        ST_MUL_QF  = 3'd5,
        ST_WR      = 3'd6
    } state_t;

    localparam int NUM_SRC   = 8;
    localparam int SRC_SEL_W = $clog2(NUM_SRC);

    // operand source indices seen by every selector
    localparam logic [SRC_SEL_W-1:0] SRC_A = 3'd0;
    localparam logic [SRC_SEL_W-1:0] SRC_B = 3'd1;
    localparam logic [SRC_SEL_W-1:0] SRC_C = 3'd2;
    localparam logic [SRC_SEL_W-1:0] SRC_D = 3'd3;
    localparam logic [SRC_SEL_W-1:0] SRC_F = 3'd4;
    localparam logic [SRC_SEL_W-1:0] SRC_X = 3'd5;
    localparam logic [SRC_SEL_W-1:0] SRC_Y = 3'd6;
    localparam logic [SRC_SEL_W-1:0] SRC_Q = 3'd7;

    // selector slots: two per arithmetic unit
    localparam int SLOT_MUL_L = 0;
    localparam int SLOT_MUL_R = 1;
    localparam int SLOT_ADD_L = 2;
    localparam int SLOT_ADD_R = 3;
    localparam int NUM_SLOT   = 4;

endpackage

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
    import sdp_pkg::*;
#(
    parameter int ITER_W = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic [ITER_W-1:0]                   iter_count,
    output state_t                              state,
    output logic                                busy,
    output logic                                done,
    output logic [NUM_SLOT-1:0][SRC_SEL_W-1:0]  sel,
    output logic                                ld_x,
    output logic                                ld_y,
    output logic                                ld_z,
    output logic                                ld_w,
    output logic                                wr_en
);

    state_t            nxt;
    logic [ITER_W-1:0] passes_left;
    logic              last_pass;

    assign last_pass = (passes_left == ITER_W'(1));

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start && (iter_count != '0)) nxt = ST_MUL_AB;
            ST_MUL_AB:  nxt = ST_ADD_CD;
            ST_ADD_CD:  nxt = ST_ADD_XY;
            ST_ADD_XY:  nxt = ST_RD_ADDR;
            ST_RD_ADDR: nxt = ST_MUL_QF;
            ST_MUL_QF:  nxt = ST_WR;
            ST_WR:      nxt = last_pass ? ST_IDLE : ST_MUL_AB;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register, pass counter and done pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            passes_left <= '0;
            done        <= 1'b0;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            if (state == ST_IDLE && start) begin
                passes_left <= iter_count;
                if (iter_count == '0) done <= 1'b1;
            end
            if (state == ST_WR) begin
                passes_left <= passes_left - ITER_W'(1);
                if (last_pass) done <= 1'b1;
            end
        end
    end

    // per-state outputs
    always_comb begin
        sel   = '0;
        ld_x  = 1'b0;
        ld_y  = 1'b0;
        ld_z  = 1'b0;
        ld_w  = 1'b0;
        wr_en = 1'b0;
        unique case (state)
            ST_MUL_AB: begin
                sel[SLOT_MUL_L] = SRC_A;
                sel[SLOT_MUL_R] = SRC_B;
                ld_x            = 1'b1;
            end
            ST_ADD_CD: begin
                sel[SLOT_ADD_L] = SRC_C;
                sel[SLOT_ADD_R] = SRC_D;
                ld_y            = 1'b1;
            end
            ST_ADD_XY: begin
                sel[SLOT_ADD_L] = SRC_X;
                sel[SLOT_ADD_R] = SRC_Y;
                ld_z            = 1'b1;
            end
            ST_MUL_QF: begin
                sel[SLOT_MUL_L] = SRC_Q;
                sel[SLOT_MUL_R] = SRC_F;
                ld_w            = 1'b1;
            end
            ST_WR:      wr_en = 1'b1;
            ST_IDLE, ST_RD_ADDR: ;
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sdp_opmux.sv
module sdp_opmux #(
    parameter int W     = 64,
    parameter int NSRC  = 8,
    localparam int SW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0][W-1:0] src,
    input  logic [SW-1:0]          sel,
    output logic [W-1:0]           out
);

    always_comb begin
        out = src[0];
        for (int i = 1; i < NSRC; i++) begin
            if (sel == SW'(i)) out = src[i];
        end
    end

endmodule

// File: rtl/sdp_ram.sv
module sdp_ram #(
    parameter int W     = 64,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic [AW-1:0] peek_addr,
    output logic [W-1:0]  peek_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata     <= mem[addr];
        peek_data <= mem[peek_addr];
    end

endmodule

// File: rtl/scatter_datapath.sv
module scatter_datapath
    import sdp_pkg::*;
#(
    parameter int W      = 64,
    parameter int DEPTH  = 512,
    parameter int ITER_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ITER_W-1:0] iter_count,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [W-1:0]      op_c,
    input  logic [W-1:0]      op_d,
    input  logic [W-1:0]      op_f,
    input  logic              load_en,
    input  logic [AW-1:0]     load_addr,
    input  logic [W-1:0]      load_data,
    input  logic [AW-1:0]     peek_addr,
    output logic [W-1:0]      peek_data,
    output logic              busy,
    output logic              done
);

    state_t                             state;
    logic [NUM_SLOT-1:0][SRC_SEL_W-1:0] sel;
    logic                               ld_x, ld_y, ld_z, ld_w, wr_en;

    logic [W-1:0] x_q, y_q, z_q, w_q, q_rd;
    logic [NUM_SRC-1:0][W-1:0]  src_bus;
    logic [NUM_SLOT-1:0][W-1:0] opnd;
    logic signed [W-1:0] prod, sum;

    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;

    sdp_ctrl #(.ITER_W(ITER_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .iter_count (iter_count),
        .state      (state),
        .busy       (busy),
        .done       (done),
        .sel        (sel),
        .ld_x       (ld_x),
        .ld_y       (ld_y),
        .ld_z       (ld_z),
        .ld_w       (ld_w),
        .wr_en      (wr_en)
    );

    always_comb begin
        src_bus        = '0;
        src_bus[SRC_A] = op_a;
        src_bus[SRC_B] = op_b;
        src_bus[SRC_C] = op_c;
        src_bus[SRC_D] = op_d;
        src_bus[SRC_F] = op_f;
        src_bus[SRC_X] = x_q;
        src_bus[SRC_Y] = y_q;
        src_bus[SRC_Q] = q_rd;
    end

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_opmux
        sdp_opmux #(.W(W), .NSRC(NUM_SRC)) mux_i (
            .src (src_bus),
            .sel (sel[g]),
            .out (opnd[g])
        );
    end

    // shared units: low W bits of the product, modular sum
    assign prod = $signed(opnd[SLOT_MUL_L]) * $signed(opnd[SLOT_MUL_R]);
    assign sum  = $signed(opnd[SLOT_ADD_L]) + $signed(opnd[SLOT_ADD_R]);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
            w_q <= '0;
        end else begin
            if (ld_x) x_q <= prod;
            if (ld_y) y_q <= sum;
            if (ld_z) z_q <= sum;
            if (ld_w) w_q <= prod;
        end
    end

    // memory port: load side port in IDLE, loop owns it otherwise
    always_comb begin
        if (busy) begin
            mem_we    = wr_en;
            mem_addr  = z_q[AW-1:0];
            mem_wdata = w_q;
        end else begin
            mem_we    = load_en;
            mem_addr  = load_addr;
            mem_wdata = load_data;
        end
    end

    sdp_ram #(.W(W), .DEPTH(DEPTH)) ram_i (
        .clk       (clk),
        .we        (mem_we),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .rdata     (q_rd),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

endmodule

// File: rtl/sdp_checker.sv
module sdp_checker
    import sdp_pkg::*;
#(
    parameter int W      = 64,
    parameter int AW     = 9,
    parameter int ITER_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ITER_W-1:0] iter_count,
    input state_t            state,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [W-1:0]      z_q
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && !done));

    assert_start_enter_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && iter_count != '0) |=> (state == ST_MUL_AB && busy));

    assert_read_then_mul_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ADDR) |=> (state == ST_MUL_QF));

    assert_wr_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR) |=> (state == ST_MUL_AB || state == ST_IDLE));

    assert_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR) |-> (mem_addr == $past(mem_addr, 2)));

    assert_z_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MUL_QF) |-> $stable(z_q));

    assert_we_only_wr_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_we) |-> (state == ST_WR));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind scatter_datapath sdp_checker #(.W(W), .AW(AW), .ITER_W(ITER_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .iter_count (iter_count),
    .state      (state),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .z_q        (z_q)
);

// File: tb/scatter_datapath_tb.sv
module scatter_datapath_tb_top;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
        logic [63:0] d;
        logic [63:0] f;
        logic [15:0] n;
        logic [63:0] pre;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{64'd3, 64'd5, 64'd7, 64'd1, 64'd2, 16'd3, 64'd10},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 64'd0,
          64'hFFFF_FFFF_FFFF_FFFD, 16'd2, 64'd7},
        '{64'h0000_0100_0000_0000, 64'h0000_0000_4000_0000,
          64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd5, 16'd4, 64'd1},
        '{64'd100, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 64'd600,
          64'd3, 16'd1, 64'hFFFF_FFFF_FFFF_FFFC},
        '{64'd1000, 64'd1000, 64'd0, 64'd0,
          64'h0000_0001_0000_0001, 16'd5, 64'h123},
        '{64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FE00, 64'd529,
          64'hFFFF_FFFF_FFFF_FFFF, 16'd6, 64'hDEAD}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] iter_count = '0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0, op_f = '0;
    logic        load_en = 1'b0;
    logic [8:0]  load_addr = '0;
    logic [63:0] load_data = '0;
    logic [8:0]  peek_addr = '0;
    logic [63:0] peek_data;
    logic        busy, done;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    scatter_datapath dut_i (
        .clk(clk), .rst(rst), .start(start), .iter_count(iter_count),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d), .op_f(op_f),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [8:0] ad, input logic [63:0] dt);
        load_en = 1'b1; load_addr = ad; load_data = dt;
        @(posedge clk); @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic peek(input logic [8:0] ad, output logic [63:0] dt);
        peek_addr = ad;
        @(posedge clk); @(negedge clk);
        dt = peek_data;
    endtask

    function automatic logic [8:0] addr_of(input vec_t v);
        logic [63:0] z;
        z = (v.a * v.b) + (v.c + v.d);
        return z[8:0];
    endfunction

    function automatic logic [63:0] model(input vec_t v);
        logic [63:0] m;
        m = v.pre;
        for (int i = 0; i < int'(v.n); i++) m = m * v.f;
        return m;
    endfunction

    // runs one vector; optionally strobes a load to spare_ad while busy
    task automatic run(input vec_t v, input bit inject, input logic [8:0] spare_ad,
                       output int cycles);
        op_a = v.a; op_b = v.b; op_c = v.c; op_d = v.d; op_f = v.f;
        iter_count = v.n;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cycles = 1;
        check("R2 busy after start", 64'(busy), 64'd1);
        while (!done && cycles < 2000) begin
            if (inject && cycles < 4) begin
                load_en = 1'b1; load_addr = spare_ad; load_data = 64'h9999;
            end else begin
                load_en = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            cycles++;
        end
        load_en = 1'b0;
        check("R2 busy low at done", 64'(busy), 64'd0);
        @(posedge clk); @(negedge clk);
        check("R8 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [63:0] rd;
        int cyc;
        logic [8:0] za, nb;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 busy in reset", 64'(busy), 64'd0);
        check("R1 done in reset", 64'(done), 64'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);

        // R10 / R9: idle load then peek
        load_word(9'd200, 64'h55);
        peek(9'd200, rd);
        check("R9 R10 idle load visible", rd, 64'h55);

        // table of vectors (R3 R4 R5 R6 R7)
        for (int k = 0; k < NVEC; k++) begin
            za = addr_of(VECS[k]);
            nb = za + 9'd1;
            load_word(za, VECS[k].pre);
            load_word(nb, 64'hA000 + 64'(k));
            run(VECS[k], 1'b0, 9'd0, cyc);
            check("R3 pass timing", 64'(cyc), 64'(6 * int'(VECS[k].n) + 1));
            peek(za, rd);
            check("R4 R5 R6 result word", rd, model(VECS[k]));
            peek(nb, rd);
            check("R7 neighbour untouched", rd, 64'hA000 + 64'(k));
        end

        // R5: negative z lands at word 511
        check("R5 alias of -1", 64'(addr_of(VECS[1])), 64'd511);

        // R9: load while busy is ignored
        load_word(9'd200, 64'h55);
        run(VECS[0], 1'b1, 9'd200, cyc);
        peek(9'd200, rd);
        check("R9 busy load ignored", rd, 64'h55);

        // R8: zero count
        load_word(9'd23, 64'h77);
        op_f = 64'd9; iter_count = 16'd0; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check("R8 zero count done", 64'(done), 64'd1);
        check("R8 zero count busy", 64'(busy), 64'd0);
        @(posedge clk); @(negedge clk);
        check("R8 zero count pulse ends", 64'(done), 64'd0);
        repeat (8) @(posedge clk);
        @(negedge clk);
        peek(9'd23, rd);
        check("R8 zero count memory", rd, 64'h77);

        // R1: memory survives reset, outputs idle
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 busy after reset", 64'(busy), 64'd0);
        rst = 1'b0;
        peek(9'd23, rd);
        check("R1 memory kept", rd, 64'h77);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule